// File: doc/BRIEF.md
# Compact 16-bit instruction executor

This block executes one 16-bit instruction per clock from the register-and-immediate subset of a compact encoding. It works against a 64-entry, 64-bit register file and keeps its own program counter. The covered instructions are two-register ALU operations, ALU operations with a 4-bit immediate, stack-pointer adjustment and short relative branches. Each 4-bit register field selects one register from a 16-entry window that starts at register 16. The stack pointer is register 2, and register 0 always reads as zero.

An upstream fetch stage presents an instruction word together with a valid strobe. The executor updates the register file and the program counter on the same clock edge. Loads, stores, longer instruction formats and reserved codes are rejected: nothing changes and a one-cycle unsupported flag is raised. A combinational debug read port returns the contents of any register.

Top module: `c16_exec`

## Requirements
- R1: While rst_ni is low, pc_o equals RST_PC (default 0x1000), unsup_o is 0, and every register reads 0 through the debug port.
- R2: An accepted word with insn[3:0]=0010 and insn[15:12] equal to 0000, 0001, 0101, 0110 or 0111 sets Rn to Rn+Rm, Rn-Rm, Rn&Rm, Rn|Rm or Rn^Rm respectively. Rn is register 16+insn[7:4] and Rm is register 16+insn[11:8].
- R3: Codes 0010 and 0011 in insn[15:12] (in both the 0010 and 0100 groups) add or subtract the low 32 bits of the operands. The 32-bit result is sign-extended to 64 bits before it is written to Rn.
- R4: When insn[3:0]=0100 and insn[15:12] is 0000 to 0011, the same four operations as in the register form are applied, with the zero-extended insn[11:8] used in place of Rm.
- R5: When insn[3:0]=0100, code 0100 adds insn[11:4]*8 to register 2 (SP), and code 0101 subtracts it.
- R6: When insn[3:0]=0100, code 0110 sets the PC to PC+2+insn[11:4]*2, and code 0111 sets it to PC+2-insn[11:4]*2. Arithmetic wraps modulo 2^64.
- R7: Every other accepted supported instruction advances the PC by 2.
- R8: An accepted word is unsupported if bit 0 is 1, if insn[3:0] is neither 0010 nor 0100, if it is code 0100 or 1xxx in the 0010 group, or if it is code 1xxx in the 0100 group. An unsupported word leaves the registers and the PC unchanged, and sets unsup_o high for the following cycle only.
- R9: A cycle with insn_valid_i low changes no register and does not change the PC. unsup_o is 0 after such a cycle.
- R10: The debug port returns register dbg_addr_i combinationally, and address 0 always returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 16 | Instruction word |
| pc_o | output | XLEN | Current program counter |
| unsup_o | output | 1 | Previous accepted word was unsupported |
| dbg_addr_i | input | log2(NREG) | Debug read register index |
| dbg_data_o | output | XLEN | Debug read data |

## Verification
The hardest case to reach is a 32-bit-wrapping operation where the sign-extension bit differs from bit 63 of the plain 64-bit result. The operands must first be built up through the 4-bit window using only small immediates. A directed prologue drives a window register negative with a 32-bit subtract, and then doubles it through register adds. After that, a sweep over all 65,536 instruction words runs in sequence against an arithmetic model. In this sweep, the register values left by earlier words become the operands of later ones, and backward branches carry the PC through long chains of wrap arithmetic.

// File: rtl/c16_pkg.sv
package c16_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDW = 3'd2,
    OP_SUBW = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6
  } alu_op_e;

  localparam int unsigned INSN_W = 16;
  localparam int unsigned IMM_W  = 12;
  localparam int unsigned BOFF_W = 9;
endpackage

// File: rtl/c16_decode.sv
module c16_decode
  import c16_pkg::*;
#(
  parameter int unsigned REG_AW   = 6,
  parameter int unsigned WIN_BASE = 16,
  parameter int unsigned SP_IDX   = 2
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic              unsup_o,
  output logic              wr_o,
  output logic [REG_AW-1:0] rd_o,
  output logic [REG_AW-1:0] rs_o,
  output logic              use_imm_o,
  output logic [IMM_W-1:0]  imm_o,
  output alu_op_e           op_o,
  output logic              br_o,
  output logic              br_back_o,
  output logic [BOFF_W-1:0] br_off_o
);
  logic [3:0] sel;
  assign sel = insn_i[15:12];

  function automatic alu_op_e map_op(input logic [3:0] code);
    case (code)
      4'h1:    return OP_SUB;
      4'h2:    return OP_ADDW;
      4'h3:    return OP_SUBW;
      4'h5:    return OP_AND;
      4'h6:    return OP_OR;
      4'h7:    return OP_XOR;
      default: return OP_ADD;
    endcase
  endfunction

  always_comb begin
    unsup_o   = 1'b1;
    wr_o      = 1'b0;
    rd_o      = REG_AW'(WIN_BASE) + REG_AW'(insn_i[7:4]);
    rs_o      = REG_AW'(WIN_BASE) + REG_AW'(insn_i[11:8]);
    use_imm_o = 1'b0;
    imm_o     = IMM_W'(insn_i[11:8]);
    op_o      = map_op(sel);
    br_o      = 1'b0;
    br_back_o = insn_i[12];
    br_off_o  = {insn_i[11:4], 1'b0};
    if (!insn_i[0]) begin
      case (insn_i[3:1])
        3'b001: begin
          if (!sel[3] && sel != 4'h4) begin
            unsup_o = 1'b0;
            wr_o    = 1'b1;
          end
        end
        3'b010: begin
          if (!sel[3]) begin
            unsup_o = 1'b0;
            case (sel[2:1])
              2'b00, 2'b01: begin
                wr_o      = 1'b1;
                use_imm_o = 1'b1;
              end
              2'b10: begin
                wr_o      = 1'b1;
                use_imm_o = 1'b1;
                rd_o      = REG_AW'(SP_IDX);
                imm_o     = {1'b0, insn_i[11:4], 3'b000};
                op_o      = sel[0] ? OP_SUB : OP_ADD;
              end
              default: br_o = 1'b1;
            endcase
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/c16_alu.sv
module c16_alu
  import c16_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o
);
  localparam int unsigned EXT_W = XLEN - WORD_W;

  logic [WORD_W-1:0] w_sum, w_dif;
  assign w_sum = a_i[WORD_W-1:0] + b_i[WORD_W-1:0];
  assign w_dif = a_i[WORD_W-1:0] - b_i[WORD_W-1:0];

  always_comb begin
    case (op_i)
      OP_SUB:  y_o = a_i - b_i;
      OP_ADDW: y_o = {{EXT_W{w_sum[WORD_W-1]}}, w_sum};
      OP_SUBW: y_o = {{EXT_W{w_dif[WORD_W-1]}}, w_dif};
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/c16_regfile.sv
module c16_regfile #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 64,
  parameter int unsigned NRD  = 3,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             wa_i,
  input  logic [XLEN-1:0]           wd_i,
  input  logic [NRD-1:0][AW-1:0]    ra_i,
  output logic [NRD-1:0][XLEN-1:0]  rd_o
);
  logic [XLEN-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = (ra_i[p] == '0) ? '0 : mem_q[ra_i[p]];
  end
endmodule

// File: rtl/c16_exec.sv
module c16_exec
  import c16_pkg::*;
#(
  parameter int unsigned    XLEN     = 64,
  parameter int unsigned    NREG     = 64,
  parameter int unsigned    WIN_BASE = 16,
  parameter int unsigned    SP_IDX   = 2,
  parameter logic [XLEN-1:0] RST_PC  = 'h1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    insn_valid_i,
  input  logic [15:0]             insn_i,
  output logic [XLEN-1:0]         pc_o,
  output logic                    unsup_o,
  input  logic [$clog2(NREG)-1:0] dbg_addr_i,
  output logic [XLEN-1:0]         dbg_data_o
);
  localparam int unsigned REG_AW = $clog2(NREG);
  localparam int unsigned NRD    = 3;
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic              d_unsup, d_wr, d_use_imm, d_br, d_back;
  logic [REG_AW-1:0] d_rd, d_rs;
  logic [IMM_W-1:0]  d_imm;
  logic [BOFF_W-1:0] d_off;
  alu_op_e           d_op;

  c16_decode #(.REG_AW(REG_AW), .WIN_BASE(WIN_BASE), .SP_IDX(SP_IDX)) i_dec (
    .insn_i    (insn_i),
    .unsup_o   (d_unsup),
    .wr_o      (d_wr),
    .rd_o      (d_rd),
    .rs_o      (d_rs),
    .use_imm_o (d_use_imm),
    .imm_o     (d_imm),
    .op_o      (d_op),
    .br_o      (d_br),
    .br_back_o (d_back),
    .br_off_o  (d_off)
  );

  logic [NRD-1:0][REG_AW-1:0] rf_ra;
  logic [NRD-1:0][XLEN-1:0]   rf_rd;
  logic [XLEN-1:0]            alu_b, alu_y;
  logic                       rf_we;

  assign rf_ra[0] = d_rd;
  assign rf_ra[1] = d_rs;
  assign rf_ra[2] = dbg_addr_i;
  assign rf_we    = insn_valid_i && d_wr;

  c16_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) i_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .wa_i   (d_rd),
    .wd_i   (alu_y),
    .ra_i   (rf_ra),
    .rd_o   (rf_rd)
  );

  assign alu_b = d_use_imm ? XLEN'(d_imm) : rf_rd[1];

  c16_alu #(.XLEN(XLEN)) i_alu (
    .a_i  (rf_rd[0]),
    .b_i  (alu_b),
    .op_i (d_op),
    .y_o  (alu_y)
  );

  logic [XLEN-1:0] pc_q, pc_seq, pc_d;
  logic            unsup_q;

  assign pc_seq = pc_q + STEP;

  always_comb begin
    pc_d = pc_q;
    if (insn_valid_i && !d_unsup) begin
      if (d_br) pc_d = d_back ? pc_seq - XLEN'(d_off) : pc_seq + XLEN'(d_off);
      else      pc_d = pc_seq;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RST_PC;
      unsup_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      unsup_q <= insn_valid_i && d_unsup;
    end
  end

  assign pc_o       = pc_q;
  assign unsup_o    = unsup_q;
  assign dbg_data_o = rf_rd[2];
endmodule

// File: rtl/c16_exec_chk.sv
module c16_exec_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned REG_AW = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              insn_valid_i,
  input logic [15:0]       insn_i,
  input logic [XLEN-1:0]   pc_o,
  input logic              unsup_o,
  input logic [REG_AW-1:0] dbg_addr_i,
  input logic [XLEN-1:0]   dbg_data_o
);
  AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> !unsup_o); // R9
  AST_IDLE_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> $stable(pc_o)); // R9
  AST_UNSUP_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> $stable(pc_o)); // R8
  AST_ALU_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && insn_i[3:0] == 4'b0010 && !insn_i[15] && insn_i[15:12] != 4'b0100)
    |=> (pc_o == $past(pc_o) + XLEN'(2))); // R7
  AST_BRANCH_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && insn_i[3:0] == 4'b0100 && insn_i[15:12] == 4'b0110)
    |=> (pc_o == $past(pc_o) + XLEN'(2) + XLEN'({$past(insn_i[11:4]), 1'b0}))); // R6
  AST_ZERO_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == '0) |-> (dbg_data_o == '0)); // R10
endmodule

bind c16_exec c16_exec_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .insn_valid_i (insn_valid_i),
  .insn_i       (insn_i),
  .pc_o         (pc_o),
  .unsup_o      (unsup_o),
  .dbg_addr_i   (dbg_addr_i),
  .dbg_data_o   (dbg_data_o)
);

// File: tb/test_c16_exec.sv
`timescale 1ns/1ps
module test_c16_exec;
  localparam int unsigned XLEN = 64;
  localparam logic [63:0] RST_PC = 64'h1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        insn_valid_i = 1'b0;
  logic [15:0] insn_i = '0;
  logic [63:0] pc_o;
  logic        unsup_o;
  logic [5:0]  dbg_addr_i = '0;
  logic [63:0] dbg_data_o;

  always #2.5 clk_i = ~clk_i;

  c16_exec i_c16_exec (
    .clk_i, .rst_ni, .insn_valid_i, .insn_i, .pc_o, .unsup_o, .dbg_addr_i, .dbg_data_o
  );

  logic [63:0] mdl [64];
  logic [63:0] mpc;
  logic        munsup;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] calc(input logic [3:0] code, input logic [63:0] a, input logic [63:0] b);
    case (code)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return sx32(a[31:0] + b[31:0]);
      4'h3: return sx32(a[31:0] - b[31:0]);
      4'h5: return a & b;
      4'h6: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  // reference behaviour from the requirements; returns target register
  function automatic int model(input logic [15:0] w);
    logic [3:0] code = w[15:12];
    int rn = 16 + int'(w[7:4]);
    int rm = 16 + int'(w[11:8]);
    logic [63:0] off8 = {53'b0, w[11:4], 3'b0};
    logic [63:0] offb = {55'b0, w[11:4], 1'b0};
    munsup = 1'b1;
    if (w[3:0] == 4'h2 && code <= 4'h7 && code != 4'h4) begin
      mdl[rn] = calc(code, mdl[rn], mdl[rm]);
      munsup = 1'b0;
      mpc = mpc + 2;
    end else if (w[3:0] == 4'h4 && code <= 4'h3) begin
      mdl[rn] = calc(code, mdl[rn], {60'b0, w[11:8]});
      munsup = 1'b0;
      mpc = mpc + 2;
    end else if (w[3:0] == 4'h4 && (code == 4'h4 || code == 4'h5)) begin
      mdl[2] = (code == 4'h4) ? mdl[2] + off8 : mdl[2] - off8;
      munsup = 1'b0;
      mpc = mpc + 2;
      return 2;
    end else if (w[3:0] == 4'h4 && (code == 4'h6 || code == 4'h7)) begin
      mpc = (code == 4'h6) ? mpc + 2 + offb : mpc + 2 - offb;
      munsup = 1'b0;
    end
    return rn;
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    logic [3:0] code = w[15:12];
    if (w[3:0] == 4'h2 && code <= 4'h7 && code != 4'h4)
      return (code == 4'h2 || code == 4'h3) ? "R3" : "R2";
    if (w[3:0] == 4'h4 && code <= 4'h3)
      return (code == 4'h2 || code == 4'h3) ? "R3" : "R4";
    if (w[3:0] == 4'h4 && (code == 4'h4 || code == 4'h5)) return "R5";
    if (w[3:0] == 4'h4 && (code == 4'h6 || code == 4'h7)) return "R6";
    return "R8";
  endfunction

  task automatic exec(input logic [15:0] w);
    int tgt;
    string t;
    insn_i = w;
    insn_valid_i = 1'b1;
    @(posedge clk_i);
    tgt = model(w);
    t = tag_of(w);
    @(negedge clk_i);
    insn_valid_i = 1'b0;
    chk(t == "R6" ? "R6" : (t == "R8" ? "R8" : "R7"), pc_o, mpc);
    chk(t == "R8" ? "R8" : t, {63'b0, unsup_o}, {63'b0, munsup});
    dbg_addr_i = 6'(tgt);
    #0.5;
    chk(t, dbg_data_o, mdl[tgt]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mpc = RST_PC;
    #7;
    chk("R1", pc_o, RST_PC);
    chk("R1", {63'b0, unsup_o}, 64'b0);
    for (int i = 0; i < 64; i++) begin
      dbg_addr_i = 6'(i);
      #0.1;
      chk("R1", dbg_data_o, 64'b0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 corner: 32-bit wrap, sign extension from zero
    exec(16'h3104);
    chk("R3", mdl[16], 64'hFFFF_FFFF_FFFF_FFFF);
    exec(16'h0002);
    exec(16'h2002);
    exec(16'h2012);
    // R8 pulse, then R9 idle
    exec(16'h0001);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R9", {63'b0, unsup_o}, 64'b0);
    chk("R9", pc_o, mpc);
    // R9: garbage word with valid low
    insn_i = 16'h0004;
    @(posedge clk_i);
    @(negedge clk_i);
    dbg_addr_i = 6'd16;
    #0.5;
    chk("R9", dbg_data_o, mdl[16]);
    chk("R9", pc_o, mpc);
    // R6 backward branch
    exec(16'h7FF4);
    exec(16'h6014);

    for (int w = 0; w < 65536; w++) begin
      exec(16'(w));
      if ((w & 255) == 0) begin
        dbg_addr_i = '0;
        #0.5;
        chk("R10", dbg_data_o, 64'b0);
      end
    end
    for (int i = 0; i < 64; i++) begin
      dbg_addr_i = 6'(i);
      #0.1;
      chk("R10", dbg_data_o, mdl[i]);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule